// File: doc/BRIEF.md
# Debug Code Capture FIFO with Timestamps

This block watches a stream of host I/O writes, presented as an address, a data byte and a one-cycle write strobe, and keeps every byte written to one programmable I/O address. Boot firmware commonly emits progress codes to such an address, and this block lets a local processor recover them after the fact, together with the time at which each one arrived.

Each captured byte is stored in a first-in first-out buffer together with the timestamp counter's value at the moment of capture. The timestamp counter advances from a prescaled tick whose rate can be set in software. A four-register interface lets firmware configure the block, pop entries, inspect status and read the running timestamp. An interrupt output requests service while entries are waiting.

Top module: `dbgp80_capture`

## Requirements
- R1: When capture is enabled and `snp_wr` is high with `snp_addr` equal to the watched address held in configuration bits [16 +: ADDR_W], the block stores one entry with `snp_data` in bits 7:0 and the timestamp value from before that clock edge, zero-extended, in bits 31:8. A write to any other address stores nothing.
- R2: A read of register 0 while entries are present returns the oldest entry on `reg_rdata` in the cycle after the read edge and removes it, so entries leave in arrival order.
- R3: A read of register 0 while the buffer is empty returns 0 and leaves the buffer contents and count unchanged.
- R4: When the buffer already holds DEPTH entries before the edge, a matching write is dropped, even if a pop happens in the same cycle, and it sets a sticky overrun flag that stays set until a 1 is written to bit 2 of register 2; writing 0 there leaves it set.
- R5: Register 2 reads back bit 0 = empty, bit 1 = full, bit 2 = overrun and bits [4 +: $clog2(DEPTH)+1] = number of stored entries; the other bits read 0.
- R6: While enabled, the timestamp advances by one every BASE_DIV × 2^sel cycles, where sel is configuration bits 3:2, and it wraps from all ones to zero (TS_W bits, 24 by default).
- R7: When configuration bit 0 (enable) is 0, matching writes are not captured and the timestamp holds its value.
- R8: Writing 1 to configuration bit 4 empties the buffer and zeroes the timestamp and its prescaler at that edge; a matching write in the same cycle is not captured, the overrun flag is untouched, and bit 4 always reads back 0.
- R9: `irq` is high exactly when configuration bit 1 (interrupt enable) is 1 and the buffer is not empty.
- R10: Register 1 reads back enable in bit 0, interrupt enable in bit 1, sel in bits 3:2 and the watched address in bits [16 +: ADDR_W]; register 3 reads the current timestamp, zero-extended.
- R11: After reset the configuration, timestamp, overrun flag and buffer are all clear, register 2 reads 1 (empty only) and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| snp_addr | input | ADDR_W | Address of the observed host I/O write |
| snp_data | input | 8 | Data byte of the observed host I/O write |
| snp_wr | input | 1 | One-cycle strobe marking an observed host I/O write |
| reg_addr | input | 2 | Register select: 0 data, 1 configuration, 2 status, 3 timestamp |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after the read strobe |
| irq | output | 1 | Entries-waiting interrupt request |

## Verification
Every result is registered once: a read strobe sampled at one rising edge puts its value on `reg_rdata` right after that edge, and captures, pops, clears and configuration writes change the status and `irq` right after the edge that sampled them. The bench drives all inputs at the falling edge, lets exactly one rising edge pass, and compares at the next falling edge. Its reference model updates at the same rising edge from the pre-edge values of its own state, so each expected read value is the one the requirements give for the state before the read.

// File: rtl/dbgp80_pkg.sv
package dbgp80_pkg;

    typedef enum logic [1:0] {
        RSEL_DATA = 2'd0,
        RSEL_CFG  = 2'd1,
        RSEL_STAT = 2'd2,
        RSEL_TIME = 2'd3
    } rsel_e;

    // configuration register fields
    localparam int CFG_EN      = 0;
    localparam int CFG_IRQ     = 1;
    localparam int CFG_SEL_LO  = 2;
    localparam int CFG_CLR     = 4;
    localparam int CFG_ADDR_LO = 16;

    // status register fields
    localparam int STAT_EMPTY  = 0;
    localparam int STAT_FULL   = 1;
    localparam int STAT_OVR    = 2;
    localparam int STAT_CNT_LO = 4;

    // entry layout
    localparam int ENTRY_TS_LO = 8;

endpackage

// File: rtl/dbgp80_tstamp.sv
module dbgp80_tstamp #(
    parameter int TS_W     = 24,
    parameter int BASE_DIV = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clr,
    input  logic [1:0]      sel,
    output logic [TS_W-1:0] ts,
    output logic            tick
);
    localparam int MAX_LIM = BASE_DIV * 8;
    localparam int PRE_W   = $clog2(MAX_LIM + 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [TS_W-1:0]  ts;
    } ts_st_t;

    ts_st_t           s_d, s_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim  = PRE_W'(BASE_DIV) << sel;
        tick = run && (s_q.pre >= (lim - 1'b1));
        s_d  = s_q;
        if (clr) begin
            s_d = '0;
        end else if (run) begin
            if (tick) begin
                s_d.pre = '0;
                s_d.ts  = s_q.ts + 1'b1;
            end else begin
                s_d.pre = s_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ts = s_q.ts;

endmodule

// File: rtl/dbgp80_fifo.sv
module dbgp80_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic                       clr,
    input  logic [WIDTH-1:0]           wdata,
    output logic [WIDTH-1:0]           head,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       empty,
    output logic                       full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ptr_st_t;

    ptr_st_t          s_d, s_q;
    logic [WIDTH-1:0] mem [DEPTH];

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            if (push) s_d.wp = s_q.wp + 1'b1;
            if (pop)  s_d.rp = s_q.rp + 1'b1;
            case ({push, pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem[s_q.wp] <= wdata;
    end

    assign head  = mem[s_q.rp];
    assign count = s_q.cnt;
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/dbgp80_capture.sv
module dbgp80_capture
    import dbgp80_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DEPTH    = 16,
    parameter int TS_W     = 24,
    parameter int BASE_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [7:0]        snp_data,
    input  logic              snp_wr,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic              en;
        logic              irq_en;
        logic [1:0]        sel;
        logic [ADDR_W-1:0] addr;
        logic              ovr;
        logic [31:0]       rdata;
    } ctl_st_t;

    ctl_st_t          st_d, st_q;
    rsel_e            rsel;
    logic             cfg_wr, stat_wr, clr, w1c_ovr;
    logic             addr_hit, fifo_push, fifo_pop, ovr_set;
    logic [31:0]      entry, fifo_head, cfg_val, stat_val;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_empty, fifo_full;
    logic [TS_W-1:0]  ts_val;
    logic             ts_tick, cap_en, ovr_flag;

    assign rsel     = rsel_e'(reg_addr);
    assign cfg_wr   = reg_wr && (rsel == RSEL_CFG);
    assign stat_wr  = reg_wr && (rsel == RSEL_STAT);
    assign clr      = cfg_wr && reg_wdata[CFG_CLR];
    assign w1c_ovr  = stat_wr && reg_wdata[STAT_OVR];
    assign cap_en   = st_q.en;
    assign ovr_flag = st_q.ovr;

    assign addr_hit  = snp_wr && st_q.en && (snp_addr == st_q.addr) && !clr;
    assign fifo_push = addr_hit && !fifo_full;
    assign ovr_set   = addr_hit && fifo_full;
    assign fifo_pop  = reg_rd && (rsel == RSEL_DATA) && !fifo_empty && !clr;
    assign entry     = 32'({ts_val, snp_data});

    dbgp80_tstamp #(.TS_W(TS_W), .BASE_DIV(BASE_DIV)) u_tstamp (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.en),
        .clr   (clr),
        .sel   (st_q.sel),
        .ts    (ts_val),
        .tick  (ts_tick)
    );

    dbgp80_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .clr   (clr),
        .wdata (entry),
        .head  (fifo_head),
        .count (fifo_count),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    always_comb begin
        cfg_val = '0;
        cfg_val[CFG_EN]                  = st_q.en;
        cfg_val[CFG_IRQ]                 = st_q.irq_en;
        cfg_val[CFG_SEL_LO +: 2]         = st_q.sel;
        cfg_val[CFG_ADDR_LO +: ADDR_W]   = st_q.addr;

        stat_val = '0;
        stat_val[STAT_EMPTY]             = fifo_empty;
        stat_val[STAT_FULL]              = fifo_full;
        stat_val[STAT_OVR]               = st_q.ovr;
        stat_val[STAT_CNT_LO +: CNT_W]   = fifo_count;
    end

    always_comb begin
        st_d = st_q;
        if (reg_rd) begin
            case (rsel)
                RSEL_DATA: st_d.rdata = fifo_empty ? 32'd0 : fifo_head;
                RSEL_CFG:  st_d.rdata = cfg_val;
                RSEL_STAT: st_d.rdata = stat_val;
                default:   st_d.rdata = 32'(ts_val);
            endcase
        end
        if (cfg_wr) begin
            st_d.en     = reg_wdata[CFG_EN];
            st_d.irq_en = reg_wdata[CFG_IRQ];
            st_d.sel    = reg_wdata[CFG_SEL_LO +: 2];
            st_d.addr   = reg_wdata[CFG_ADDR_LO +: ADDR_W];
        end
        if (w1c_ovr) st_d.ovr = 1'b0;
        if (ovr_set) st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
    assign irq       = st_q.irq_en && !fifo_empty;

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[15:5], ts_tick, cap_en, ovr_flag};

endmodule

// File: rtl/dbgp80_chk.sv
module dbgp80_chk #(
    parameter int DEPTH = 16,
    parameter int TS_W  = 24
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     run,
    input logic                     clr,
    input logic                     tick,
    input logic [TS_W-1:0]          ts,
    input logic [$clog2(DEPTH):0]   count,
    input logic                     empty,
    input logic                     push,
    input logic                     ovr,
    input logic                     w1c,
    input logic                     irq
);
    // R4: the buffer never holds more than DEPTH entries
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= ($clog2(DEPTH)+1)'(DEPTH));

    // R4: overrun stays set until written with 1
    p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !w1c) |=> ovr);

    // R3: an empty buffer with no capture stays empty
    p_empty_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> empty);

    // R9: no interrupt request after an idle empty cycle
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !push) |=> !irq);

    // R6: timestamp wraps from all ones to zero
    p_ts_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && (ts == '1)) |=> (ts == '0));

    // R7: timestamp frozen while disabled
    p_ts_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(ts));

    // R8: clear leaves the timestamp at zero
    p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ts == '0) && empty);

endmodule

bind dbgp80_capture dbgp80_chk #(.DEPTH(DEPTH), .TS_W(TS_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (cap_en),
    .clr   (clr),
    .tick  (ts_tick),
    .ts    (ts_val),
    .count (fifo_count),
    .empty (fifo_empty),
    .push  (fifo_push),
    .ovr   (ovr_flag),
    .w1c   (w1c_ovr),
    .irq   (irq)
);

// File: tb/dbgp80_capture_tb.sv
module dbgp80_capture_tb;
    localparam int ADDR_W   = 16;
    localparam int DEPTH    = 16;
    localparam int TS_W     = 6;
    localparam int BASE_DIV = 2;
    localparam int TSMOD    = 1 << TS_W;
    localparam logic [15:0] WATCH = 16'h0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] snp_addr = '0;
    logic [7:0]  snp_data = '0;
    logic        snp_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dbgp80_capture #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .TS_W(TS_W), .BASE_DIV(BASE_DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .snp_addr(snp_addr), .snp_data(snp_data), .snp_wr(snp_wr),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // reference model, updated from pre-edge state
    logic [31:0] mq[$];
    bit          m_en, m_irqen, m_ovr;
    logic [1:0]  m_sel;
    logic [15:0] m_addr;
    int          m_ts, m_pre;
    logic [31:0] exp_rd;
    bit          exp_irq;

    always @(posedge clk) begin
        int lim;
        bit clr, match, was_full, pop;
        logic [31:0] e;
        if (!rst_n) begin
            mq.delete();
            m_en = 0; m_irqen = 0; m_ovr = 0; m_sel = 0; m_addr = 0;
            m_ts = 0; m_pre = 0; exp_rd = 0; exp_irq = 0;
        end else begin
            lim = BASE_DIV << m_sel;
            if (reg_rd) begin
                case (reg_addr)
                    2'd0: exp_rd = (mq.size() != 0) ? mq[0] : 32'd0;
                    2'd1: exp_rd = {m_addr, 12'd0, m_sel, m_irqen, m_en};
                    2'd2: exp_rd = (32'(mq.size()) << 4) | {29'd0, m_ovr, (mq.size() == DEPTH), (mq.size() == 0)};
                    default: exp_rd = 32'(m_ts);
                endcase
            end
            clr      = reg_wr && reg_addr == 2'd1 && reg_wdata[4];
            match    = snp_wr && m_en && snp_addr == m_addr && !clr;
            was_full = (mq.size() == DEPTH);
            pop      = reg_rd && reg_addr == 2'd0 && mq.size() != 0;
            e        = (32'(m_ts) << 8) | 32'(snp_data);
            if (clr) mq.delete();
            else begin
                if (pop) void'(mq.pop_front());
                if (match && !was_full) mq.push_back(e);
            end
            if (reg_wr && reg_addr == 2'd2 && reg_wdata[2]) m_ovr = 0;
            if (match && was_full) m_ovr = 1;
            if (clr) begin m_ts = 0; m_pre = 0; end
            else if (m_en) begin
                if (m_pre >= lim - 1) begin m_pre = 0; m_ts = (m_ts + 1) % TSMOD; end
                else m_pre = m_pre + 1;
            end
            if (reg_wr && reg_addr == 2'd1) begin
                m_en = reg_wdata[0]; m_irqen = reg_wdata[1];
                m_sel = reg_wdata[3:2]; m_addr = reg_wdata[31:16];
            end
            exp_irq = m_irqen && mq.size() != 0;
        end
    end

    function automatic logic [31:0] cfgw(bit en, bit ie, logic [1:0] sel, bit clr);
        return {WATCH, 11'd0, clr, sel, ie, en};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(bit sn, logic [15:0] sa, logic [7:0] sd,
                        bit rd, bit wr, logic [1:0] ra, logic [31:0] wd, string tag);
        snp_wr = sn; snp_addr = sa; snp_data = sd;
        reg_rd = rd; reg_wr = wr; reg_addr = ra; reg_wdata = wd;
        @(negedge clk);
        snp_wr = 0; reg_rd = 0; reg_wr = 0;
        if (rd) check(tag, reg_rdata, exp_rd);
        check("R9 irq", {31'd0, irq}, {31'd0, exp_irq});
    endtask

    task automatic rd(logic [1:0] ra, string tag);
        step(0, 0, 0, 1, 0, ra, 0, tag);
    endtask
    task automatic wr(logic [1:0] ra, logic [31:0] wd);
        step(0, 0, 0, 0, 1, ra, wd, "");
    endtask
    task automatic snoop(logic [15:0] sa, logic [7:0] sd);
        step(1, sa, sd, 0, 0, 0, 0, "");
    endtask
    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, "");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        rd(2'd0, "R11 data"); rd(2'd1, "R11 cfg"); rd(2'd2, "R11 status"); rd(2'd3, "R11 time");
        check("R11 irq", {31'd0, irq}, 32'd0);

        wr(2'd1, cfgw(1, 1, 2'd0, 1));
        rd(2'd1, "R10 cfg readback");

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            int p = $urandom % 100;
            logic [1:0] ra = 2'($urandom % 4);
            logic [15:0] sa = ($urandom % 4 != 0) ? WATCH : 16'($urandom);
            logic [7:0] sd = 8'($urandom);
            if (p < 40) snoop(sa, sd);
            else if (p < 80) begin
                case (ra)
                    2'd0: rd(ra, "R2 data");
                    2'd1: rd(ra, "R10 cfg");
                    2'd2: rd(ra, "R5 status");
                    default: rd(ra, "R6 time");
                endcase
            end else if (p < 82) wr(2'd1, cfgw(1, 1, 2'($urandom % 4), 0));
            else if (p < 84) wr(2'd2, 32'($urandom % 8));
            else if (p < 86) step(1, sa, sd, 1, 0, 2'd0, 0, "R2 data+capture");
            else idle(1);
        end

        // R4 full, overrun, write-0 keeps, write-1 clears
        wr(2'd1, cfgw(1, 1, 2'd1, 1));
        for (int i = 0; i < DEPTH + 2; i++) snoop(WATCH, 8'(i + 8'h10));
        rd(2'd2, "R4 full+overrun");
        step(1, WATCH, 8'hEE, 1, 0, 2'd0, 0, "R4 pop while full");
        rd(2'd2, "R4 no admit on full pop");
        wr(2'd2, 32'd0);
        rd(2'd2, "R4 overrun kept");
        wr(2'd2, 32'd4);
        rd(2'd2, "R4 overrun cleared");

        // R2 drain in order, R3 empty reads
        for (int i = 0; i < DEPTH; i++) rd(2'd0, "R2 order");
        rd(2'd0, "R3 empty read");
        rd(2'd2, "R3 status after empty read");
        rd(2'd0, "R3 empty read again");

        // R1 non-matching address
        snoop(WATCH ^ 16'h0100, 8'h55);
        rd(2'd2, "R1 non-matching ignored");
        snoop(WATCH, 8'h5A);
        rd(2'd0, "R1 entry layout");

        // R9 interrupt masked
        wr(2'd1, cfgw(1, 0, 2'd0, 0));
        snoop(WATCH, 8'h01);
        check("R9 masked irq", {31'd0, irq}, 32'd0);
        wr(2'd1, cfgw(1, 1, 2'd0, 0));
        check("R9 enabled irq", {31'd0, irq}, 32'd1);

        // R7 disabled
        wr(2'd1, cfgw(0, 1, 2'd0, 0));
        rd(2'd3, "R7 time");
        idle(20);
        snoop(WATCH, 8'h77);
        rd(2'd3, "R7 time frozen");
        rd(2'd2, "R7 no capture");

        // R8 clear with same-cycle capture
        wr(2'd1, cfgw(1, 1, 2'd0, 0));
        snoop(WATCH, 8'h02);
        wr(2'd2, 32'd0);
        step(1, WATCH, 8'h03, 0, 1, 2'd1, cfgw(1, 1, 2'd3, 1), "");
        rd(2'd2, "R8 cleared status");
        rd(2'd1, "R8 clear bit reads 0");
        rd(2'd3, "R8 time zero");

        // R6 rate and wrap at several selections
        for (int s = 0; s < 4; s++) begin
            wr(2'd1, cfgw(1, 1, 2'(s), 1));
            for (int k = 0; k < 12; k++) begin
                idle(s * 7 + 3);
                rd(2'd3, "R6 time rate");
            end
        end
        wr(2'd1, cfgw(1, 1, 2'd0, 1));
        idle(TSMOD * BASE_DIV - 3);
        rd(2'd3, "R6 before wrap");
        rd(2'd3, "R6 at wrap");
        snoop(WATCH, 8'hA5);
        rd(2'd0, "R6 stamp after wrap");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule